// File: doc/BRIEF.md
# FFT Stage Result Write Address Generator

This block produces the write side of one radix-2 FFT stage on a tile. Every butterfly result carries two complex outputs, a and b. They are stored in two banks, A and B, and each bank holds half of the tile's points. The real and imaginary memories of a bank share one address and one write enable. The block is told when each half of a stage begins and which half it is. It is also told which write pattern the stage uses. For every valid butterfly result it then raises both bank write enables, presents one address per bank, and drives a steering flag. That flag tells the datapath whether result b goes to bank A and result a to bank B.

There are three write patterns. The interleaved pattern is used for every stage but the last. Each bank steps by two, the two banks start on opposite parities, and in the second half the parities and the bank roles are exchanged. The sequential pattern steps both banks by one from zero and runs straight through both halves. The reversed pattern is the sequential one with each bank address bit-reversed, and it is used for the last stage. Because results alternate between the two banks, the bank choice acts as the missing low bit, so the stored order comes out fully bit-reversed. Each address counter is loaded with its start value minus its step, and the step is added before every write.

Top module: `fft_wr_addr_gen`

## Requirements
- R1: With mode code 0 (interleaved), the k-th write (k from 0) of a first half goes to address 2k in bank A and 2k+1 in bank B.
- R2: With mode code 0, the k-th write of a second half goes to address 2k+1 in bank A and 2k in bank B.
- R3: `res_swap` is 1 on every write of an interleaved second half and 0 on every write in all other cases.
- R4: With mode code 1 (sequential; code 3 behaves the same), both banks write address k during the first half. A second-half start does not reload the counters, so the second half writes address NPT/4+k.
- R5: With mode code 2 (reversed), each bank address is the sequential address of R4 with its PTS_LOG2-1 bits in reverse order.
- R6: While a half is open, both bank write enables follow `res_valid`. A half closes after NPT/4 writes, and any `res_valid` after that leaves both enables low.
- R7: `res_valid` in the same cycle as `seg_start`, or before any half has been started, writes nothing.
- R8: `stage_done` is a one-cycle pulse in the cycle after the NPT/4-th write of a second half. It is never raised after a first half.
- R9: After reset, both write enables, `res_swap` and `stage_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_start | input | 1 | Pulse that opens a half of a stage |
| seg_sel | input | 1 | Which half is opened: 0 first, 1 second |
| wr_mode | input | 2 | Write pattern: 0 interleaved, 1 sequential, 2 reversed, 3 sequential |
| res_valid | input | 1 | A butterfly result is ready to store this cycle |
| bank_a_we | output | 1 | Write enable for bank A (real and imaginary) |
| bank_a_addr | output | PTS_LOG2-1 | Write address for bank A |
| bank_b_we | output | 1 | Write enable for bank B (real and imaginary) |
| bank_b_addr | output | PTS_LOG2-1 | Write address for bank B |
| res_swap | output | 1 | 1: result b goes to bank A and result a to bank B |
| stage_done | output | 1 | Pulse after the final write of a stage |

## Verification
The hardest case to reach is the sequential and reversed second half. Its correctness depends on the counter state left by the first half, and the second-half start must leave that state alone. The stimulus therefore runs whole stages in every mode. Random idle gaps are placed between results, and stages of different modes are run back to back, so a counter that is wrongly reloaded or carried over between stages shows up in the second-half addresses. Extra results after a half has closed, and a result that coincides with a start pulse, are driven directly to confirm that nothing is written.

// File: rtl/fft_wr_pkg.sv
package fft_wr_pkg;

    typedef enum logic [1:0] {
        WM_INTERLEAVE = 2'd0,
        WM_SEQUENTIAL = 2'd1,
        WM_REVERSED   = 2'd2,
        WM_SEQ_ALT    = 2'd3
    } wr_mode_e;

    typedef struct packed {
        wr_mode_e mode;
        logic     second;
    } seg_cfg_t;

    function automatic logic [1:0] step_of(wr_mode_e m);
        return (m == WM_INTERLEAVE) ? 2'd2 : 2'd1;
    endfunction

    function automatic logic is_interleave(wr_mode_e m);
        return m == WM_INTERLEAVE;
    endfunction

endpackage

// File: rtl/fft_wr_seq.sv
module fft_wr_seq
    import fft_wr_pkg::*;
#(
    parameter int PER_HALF = 256
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     seg_start,
    input  logic     seg_sel,
    input  logic [1:0] mode_in,
    input  logic     res_valid,
    output seg_cfg_t cfg,
    output logic     active,
    output logic     wr_fire,
    output logic     ctr_load,
    output logic     stage_done
);
    localparam int CW = $clog2(PER_HALF + 1);

    logic [CW-1:0] wcnt;
    logic          last_wr;

    assign wr_fire  = active && res_valid && !seg_start;
    assign last_wr  = (wcnt == CW'(PER_HALF - 1));
    assign ctr_load = seg_start && (is_interleave(wr_mode_e'(mode_in)) || !seg_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg        <= '{mode: WM_INTERLEAVE, second: 1'b0};
            active     <= 1'b0;
            wcnt       <= '0;
            stage_done <= 1'b0;
        end else begin
            stage_done <= wr_fire && last_wr && cfg.second;
            if (seg_start) begin
                cfg    <= '{mode: wr_mode_e'(mode_in), second: seg_sel};
                active <= 1'b1;
                wcnt   <= '0;
            end else if (wr_fire) begin
                wcnt <= wcnt + 1'b1;
                if (last_wr) active <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fft_bank_ctr.sv
module fft_bank_ctr #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          fire,
    input  logic [1:0]    step,
    input  logic          rev_en,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] cnt;
    logic [AW-1:0] nxt;
    logic [AW-1:0] nxt_rev;

    assign nxt = cnt + AW'(step);

    for (genvar i = 0; i < AW; i++) begin : g_rev
        assign nxt_rev[i] = nxt[AW-1-i];
    end

    assign addr = rev_en ? nxt_rev : nxt;

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= load_val;
        else if (fire) cnt <= nxt;
    end
endmodule

// File: rtl/fft_wr_addr_gen.sv
module fft_wr_addr_gen
    import fft_wr_pkg::*;
#(
    parameter int PTS_LOG2 = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                seg_start,
    input  logic                seg_sel,
    input  logic [1:0]          wr_mode,
    input  logic                res_valid,
    output logic                bank_a_we,
    output logic [PTS_LOG2-2:0] bank_a_addr,
    output logic                bank_b_we,
    output logic [PTS_LOG2-2:0] bank_b_addr,
    output logic                res_swap,
    output logic                stage_done
);
    localparam int NPT      = 1 << PTS_LOG2;
    localparam int AW       = PTS_LOG2 - 1;
    localparam int PER_HALF = NPT / 4;
    localparam int NBANK    = 2;

    seg_cfg_t cfg;
    logic     active;
    logic     wr_fire;
    logic     ctr_load;
    logic [1:0] step_q;
    logic [AW-1:0] addr_v [NBANK];

    fft_wr_seq #(.PER_HALF(PER_HALF)) seq_i (
        .clk        (clk),
        .rst        (rst),
        .seg_start  (seg_start),
        .seg_sel    (seg_sel),
        .mode_in    (wr_mode),
        .res_valid  (res_valid),
        .cfg        (cfg),
        .active     (active),
        .wr_fire    (wr_fire),
        .ctr_load   (ctr_load),
        .stage_done (stage_done)
    );

    assign step_q = step_of(cfg.mode);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [AW-1:0] start_v;
        logic [AW-1:0] load_v;
        // interleaved: bank A even in first half, odd in second; B opposite
        assign start_v = is_interleave(wr_mode_e'(wr_mode))
                       ? AW'((b != 0) ^ seg_sel) : '0;
        assign load_v  = start_v - AW'(step_of(wr_mode_e'(wr_mode)));

        fft_bank_ctr #(.AW(AW)) ctr_i (
            .clk      (clk),
            .rst      (rst),
            .load     (ctr_load),
            .load_val (load_v),
            .fire     (wr_fire),
            .step     (step_q),
            .rev_en   (cfg.mode == WM_REVERSED),
            .addr     (addr_v[b])
        );
    end

    assign bank_a_we   = wr_fire;
    assign bank_b_we   = wr_fire;
    assign bank_a_addr = addr_v[0];
    assign bank_b_addr = addr_v[1];
    assign res_swap    = is_interleave(cfg.mode) && cfg.second;
endmodule

// File: rtl/fft_wr_addr_gen_chk.sv
module fft_wr_addr_gen_chk
    import fft_wr_pkg::*;
#(
    parameter int AW = 9
) (
    input logic          clk,
    input logic          rst,
    input logic          bank_a_we,
    input logic [AW-1:0] bank_a_addr,
    input logic [AW-1:0] bank_b_addr,
    input logic          res_swap,
    input logic          stage_done,
    input logic          active,
    input seg_cfg_t      cfg
);
    // R1
    addr_parity_chk: assert property (@(posedge clk) disable iff (rst)
        (bank_a_we && cfg.mode == WM_INTERLEAVE) |-> (bank_a_addr[0] != bank_b_addr[0]));

    // R3
    swap_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        res_swap |-> (cfg.second && cfg.mode == WM_INTERLEAVE));

    // R6
    we_active_chk: assert property (@(posedge clk) disable iff (rst)
        bank_a_we |-> active);

    // R8
    done_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stage_done) |-> $past(bank_a_we));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        stage_done |=> !stage_done);
endmodule

bind fft_wr_addr_gen fft_wr_addr_gen_chk #(.AW(AW)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .bank_a_we   (bank_a_we),
    .bank_a_addr (bank_a_addr),
    .bank_b_addr (bank_b_addr),
    .res_swap    (res_swap),
    .stage_done  (stage_done),
    .active      (active),
    .cfg         (cfg)
);

// File: tb/fft_wr_addr_gen_tb_top.sv
module fft_wr_addr_gen_tb_top;
    localparam int PTS_LOG2 = 5;
    localparam int NPT      = 1 << PTS_LOG2;
    localparam int AW       = PTS_LOG2 - 1;
    localparam int PH       = NPT / 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic seg_start = 1'b0;
    logic seg_sel = 1'b0;
    logic [1:0] wr_mode = 2'd0;
    logic res_valid = 1'b0;
    logic bank_a_we, bank_b_we, res_swap, stage_done;
    logic [AW-1:0] bank_a_addr, bank_b_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fft_wr_addr_gen #(.PTS_LOG2(PTS_LOG2)) dut_i (
        .clk(clk), .rst(rst), .seg_start(seg_start), .seg_sel(seg_sel),
        .wr_mode(wr_mode), .res_valid(res_valid),
        .bank_a_we(bank_a_we), .bank_a_addr(bank_a_addr),
        .bank_b_we(bank_b_we), .bank_b_addr(bank_b_addr),
        .res_swap(res_swap), .stage_done(stage_done)
    );

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int brev(int v);
        int r = 0;
        for (int i = 0; i < AW; i++) if (v[i]) r |= 1 << (AW - 1 - i);
        return r;
    endfunction

    function automatic int exp_addr(int mode, int half, int k, int bank);
        int lin;
        if (mode == 0) return 2 * k + (half ^ bank);
        lin = half * PH + k;
        return (mode == 2) ? brev(lin) : lin;
    endfunction

    task automatic run_half(int mode, int half, bit collide);
        @(negedge clk);
        seg_start = 1'b1; seg_sel = half[0]; wr_mode = mode[1:0];
        res_valid = collide;
        #1;
        if (collide) chk("R7 start-cycle valid", int'(bank_a_we), 0);
        @(negedge clk);
        seg_start = 1'b0; res_valid = 1'b0;
        for (int k = 0; k < PH; k++) begin
            int gap = $urandom_range(0, 2);
            for (int g = 0; g < gap; g++) begin
                #1; chk("R6 idle no write", int'(bank_a_we | bank_b_we), 0);
                @(negedge clk);
            end
            res_valid = 1'b1;
            #1;
            chk("R6 we", int'(bank_a_we & bank_b_we), 1);
            chk(mode == 0 ? (half ? "R2 addr A" : "R1 addr A")
                          : (mode == 2 ? "R5 addr A" : "R4 addr A"),
                int'(bank_a_addr), exp_addr(mode, half, k, 0));
            chk(mode == 0 ? (half ? "R2 addr B" : "R1 addr B")
                          : (mode == 2 ? "R5 addr B" : "R4 addr B"),
                int'(bank_b_addr), exp_addr(mode, half, k, 1));
            chk("R3 swap", int'(res_swap), (mode == 0 && half == 1) ? 1 : 0);
            @(negedge clk);
            res_valid = 1'b0;
        end
        chk("R8 done after half", int'(stage_done), half);
        res_valid = 1'b1;
        #1;
        chk("R6 extra valid ignored", int'(bank_a_we | bank_b_we), 0);
        @(negedge clk);
        res_valid = 1'b0;
        chk("R8 done single cycle", int'(stage_done), 0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        #1;
        chk("R9 reset we", int'(bank_a_we | bank_b_we), 0);
        chk("R9 reset swap", int'(res_swap), 0);
        chk("R9 reset done", int'(stage_done), 0);
        @(negedge clk);
        rst = 1'b0;
        res_valid = 1'b1;
        #1;
        chk("R7 valid before start", int'(bank_a_we), 0);
        @(negedge clk);
        res_valid = 1'b0;
        // directed stage sequence: interleaved stages then reversed last stage
        run_half(0, 0, 1'b1); run_half(0, 1, 1'b0);
        run_half(0, 0, 1'b0); run_half(0, 1, 1'b0);
        run_half(2, 0, 1'b0); run_half(2, 1, 1'b0);
        run_half(1, 0, 1'b0); run_half(1, 1, 1'b1);
        run_half(3, 0, 1'b0); run_half(3, 1, 1'b0);
        // random mix of whole stages
        for (int s = 0; s < 12; s++) begin
            int m = $urandom_range(0, 3);
            run_half(m, 0, $urandom_range(0, 1) == 1);
            run_half(m, 1, 1'b0);
        end
        finished = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule